// File: doc/BRIEF.md
# Vendor-Command Lock Gate

This block sits between an ATA command decoder and the command execution path. It screens vendor-specific and reserved command codes. Each decoded command arrives as a command byte, a features byte and a one-cycle strobe. One cycle later the block returns a verdict:

- run the command with its normal protocol,
- forward it with a selected protocol code,
- abort it with a fixed status and error pair, or
- treat it as an internal control action.

Special control commands unlock three independent kinds of access:

- vendor-specific codes,
- reserved codes,
- individually listed commands held in a small protocol table.

The table is keyed by command code and by a masked features value. Control commands also set a general protocol code and write table entries. A lock command returns everything to the locked default.

The lock state is an eight-state machine whose states are:

- `LK_LOCKED`
- `LK_VS`
- `LK_RSV`
- `LK_IND`
- `LK_VS_RSV`
- `LK_VS_IND`
- `LK_RSV_IND`
- `LK_ALL`

Its transitions are:

- Add-VS sets the vendor kind.
- Add-RSV sets the reserved kind.
- Add-IND sets the listed kind.
- Lock goes to `LK_LOCKED` from any state.
- Force-lock goes to `LK_LOCKED` on any hardware reset, COMRESET or COMINIT event.

Each add transition moves to the state that joins the new kind to those already held; an add of a kind already held stays put. Soft reset causes no transition.

Top module: `vcmd_lock_gate`

## Requirements
- R1: A hardware reset, COMRESET or COMINIT event forces `LK_LOCKED`, clears the general protocol code to 00h and empties the table. A command strobed in the same cycle as such an event gets no response (`res_valid` stays 0).
- R2: A soft-reset event changes neither the lock state, the general protocol code nor the table.
- R3: In `LK_LOCKED`, every vendor-specific code (80h to 8Fh) and every reserved code (F2h to FFh) is answered with kind ABORT (2), protocol 00h, status 51h and error 04h.
- R4: Any code other than these ranges and F1h is answered with kind STD (0), protocol 00h, status 50h and error 00h in every state.
- R5: Control code F1h with features D5h, 12h or 32h adds the vendor, reserved or listed kind respectively. The response is kind CTRL (3) with status 50h.
- R6: F1h with features F0h answers CTRL and returns to `LK_LOCKED` from any state. It also clears the general protocol code and the table.
- R7: F1h with features 87h loads `arg_proto` into the general protocol code when the state is not `LK_LOCKED`. In `LK_LOCKED` it is aborted and has no effect.
- R8: A vendor-specific code whose kind is unlocked is forwarded (kind FWD = 1) with the general protocol code. The same applies to a reserved code whose kind is unlocked. A protocol code of 00h turns the command into an abort with status 51h and error 04h.
- R9: With the listed kind unlocked, a vendor-specific or reserved command is forwarded with a table entry's protocol when that entry has an equal command code and a features value equal under the mask. A mask bit of 0 makes that features bit a don't-care. The table takes precedence over the general code, and an entry protocol of 00h aborts.
- R10: When several table entries match, the one with the lowest index wins.
- R11: F1h with features 88h writes the entry given by `arg_cmd`, `arg_feat`, `arg_mask` and `arg_proto`. It overwrites the lowest entry with identical command, features and mask, otherwise the lowest free one. It is aborted with no effect when the table is full or the state is `LK_LOCKED`.
- R12: Every strobed command gets exactly one response in the next cycle. After reset `res_valid` is 0.
- R13: F1h with any other features value is aborted and leaves the state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_reset_evt | input | 1 | Hardware reset event pulse |
| comreset_evt | input | 1 | COMRESET event pulse |
| cominit_evt | input | 1 | COMINIT event pulse |
| srst_evt | input | 1 | Soft-reset event pulse (no effect) |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 8 | Command code |
| feat_code | input | 8 | Features code |
| arg_cmd | input | 8 | Entry command code for a set-entry action |
| arg_feat | input | 8 | Entry features value for a set-entry action |
| arg_mask | input | 8 | Entry features mask for a set-entry action |
| arg_proto | input | 8 | Protocol value for set-general or set-entry |
| res_valid | output | 1 | Response strobe |
| res_kind | output | 2 | 0 STD, 1 FWD, 2 ABORT, 3 CTRL |
| res_proto | output | 8 | Protocol code for FWD, else 00h |
| res_status | output | 8 | 51h on abort, else 50h |
| res_error | output | 8 | 04h on abort, else 00h |

## Verification
The bench builds the block with a three-entry table instead of the default four. This lets a handful of set-entry commands reach a full table, so the rejected fourth write and the lowest-index tie-break are both exercised directly. The ranges and feature codes keep their defaults. Random traffic is therefore biased toward codes that sit in the vendor, reserved and control ranges, and toward table keys that collide.

// File: rtl/vcl_pkg.sv
package vcl_pkg;
    localparam int BYTE_W = 8;

    // bit0 vendor kind, bit1 reserved kind, bit2 listed kind
    typedef enum logic [2:0] {
        LK_LOCKED  = 3'b000,
        LK_VS      = 3'b001,
        LK_RSV     = 3'b010,
        LK_VS_RSV  = 3'b011,
        LK_IND     = 3'b100,
        LK_VS_IND  = 3'b101,
        LK_RSV_IND = 3'b110,
        LK_ALL     = 3'b111
    } lock_state_e;

    typedef enum logic [1:0] {
        RK_STD   = 2'd0,
        RK_FWD   = 2'd1,
        RK_ABORT = 2'd2,
        RK_CTRL  = 2'd3
    } resp_kind_e;

    typedef enum logic [2:0] {
        OP_NONE    = 3'd0,
        OP_ADD_VS  = 3'd1,
        OP_ADD_RSV = 3'd2,
        OP_ADD_IND = 3'd3,
        OP_LOCK    = 3'd4
    } lock_op_e;

    typedef struct packed {
        logic              valid;
        logic [BYTE_W-1:0] cmd;
        logic [BYTE_W-1:0] feat;
        logic [BYTE_W-1:0] mask;
        logic [BYTE_W-1:0] proto;
    } tbl_entry_t;
endpackage

// File: rtl/vcl_classify.sv
module vcl_classify
    import vcl_pkg::*;
#(
    parameter logic [BYTE_W-1:0] VS_LO     = 8'h80,
    parameter logic [BYTE_W-1:0] VS_HI     = 8'h8F,
    parameter logic [BYTE_W-1:0] RSV_LO    = 8'hF2,
    parameter logic [BYTE_W-1:0] RSV_HI    = 8'hFF,
    parameter logic [BYTE_W-1:0] CTRL_CODE = 8'hF1
) (
    input  logic [BYTE_W-1:0] code,
    output logic              is_ctrl,
    output logic              is_vs,
    output logic              is_rsv
);
    always_comb begin
        is_ctrl = (code == CTRL_CODE);
        is_vs   = !is_ctrl && (code >= VS_LO) && (code <= VS_HI);
        is_rsv  = !is_ctrl && (code >= RSV_LO) && (code <= RSV_HI);
    end
endmodule

// File: rtl/vcl_lock_fsm.sv
module vcl_lock_fsm
    import vcl_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        force_lock,
    input  lock_op_e    op,
    output lock_state_e state
);
    lock_state_e nxt;

    always_ff @(posedge clk) begin
        if (!rst_n || force_lock) state <= LK_LOCKED;
        else                      state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (op)
            OP_NONE:    nxt = state;
            OP_ADD_VS:  nxt = lock_state_e'(state | LK_VS);
            OP_ADD_RSV: nxt = lock_state_e'(state | LK_RSV);
            OP_ADD_IND: nxt = lock_state_e'(state | LK_IND);
            OP_LOCK:    nxt = LK_LOCKED;
            default:    nxt = state;
        endcase
    end

    assert_force_locks_R1: assert property (@(posedge clk) disable iff (!rst_n)
        force_lock |=> state == LK_LOCKED);
    assert_lock_any_R6: assert property (@(posedge clk) disable iff (!rst_n)
        op == OP_LOCK |=> state == LK_LOCKED);
    assert_add_vs_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_ADD_VS && !force_lock) |=> state[0]);
    assert_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_NONE && !force_lock) |=> $stable(state));
endmodule

// File: rtl/vcl_proto_table.sv
module vcl_proto_table
    import vcl_pkg::*;
#(
    parameter int ENTRIES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic [BYTE_W-1:0] look_cmd,
    input  logic [BYTE_W-1:0] look_feat,
    output logic              hit,
    output logic [BYTE_W-1:0] hit_proto,
    input  logic              wr_req,
    input  logic [BYTE_W-1:0] wr_cmd,
    input  logic [BYTE_W-1:0] wr_feat,
    input  logic [BYTE_W-1:0] wr_mask,
    input  logic [BYTE_W-1:0] wr_proto,
    output logic              wr_ok
);
    tbl_entry_t         ent [ENTRIES];
    logic [ENTRIES-1:0] look_m, key_m, free_m, cand, wr_sel;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        assign look_m[g] = ent[g].valid && (ent[g].cmd == look_cmd) &&
                           (((look_feat ^ ent[g].feat) & ent[g].mask) == '0);
        assign key_m[g]  = ent[g].valid && (ent[g].cmd == wr_cmd) &&
                           (ent[g].feat == wr_feat) && (ent[g].mask == wr_mask);
        assign free_m[g] = !ent[g].valid;
    end

    // existing key first, else free slot; lowest index by bit isolation
    assign cand   = (|key_m) ? key_m : free_m;
    assign wr_sel = cand & ((~cand) + ENTRIES'(1));
    assign wr_ok  = |cand;

    always_comb begin
        hit       = 1'b0;
        hit_proto = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (look_m[i]) begin
                hit       = 1'b1;
                hit_proto = ent[i].proto;
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < ENTRIES; i++) begin
            if (!rst_n || clear)
                ent[i] <= '0;
            else if (wr_req && wr_sel[i])
                ent[i] <= '{1'b1, wr_cmd, wr_feat, wr_mask, wr_proto};
        end
    end

    assert_clear_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !hit);
endmodule

// File: rtl/vcmd_lock_gate.sv
module vcmd_lock_gate
    import vcl_pkg::*;
#(
    parameter int                ENTRIES      = 4,
    parameter logic [BYTE_W-1:0] VS_LO        = 8'h80,
    parameter logic [BYTE_W-1:0] VS_HI        = 8'h8F,
    parameter logic [BYTE_W-1:0] RSV_LO       = 8'hF2,
    parameter logic [BYTE_W-1:0] RSV_HI       = 8'hFF,
    parameter logic [BYTE_W-1:0] CTRL_CODE    = 8'hF1,
    parameter logic [BYTE_W-1:0] FT_UNL_VS    = 8'hD5,
    parameter logic [BYTE_W-1:0] FT_UNL_RSV   = 8'h12,
    parameter logic [BYTE_W-1:0] FT_UNL_IND   = 8'h32,
    parameter logic [BYTE_W-1:0] FT_LOCK      = 8'hF0,
    parameter logic [BYTE_W-1:0] FT_SET_GEN   = 8'h87,
    parameter logic [BYTE_W-1:0] FT_SET_ENT   = 8'h88,
    parameter logic [BYTE_W-1:0] ST_OK        = 8'h50,
    parameter logic [BYTE_W-1:0] ST_ABORT     = 8'h51,
    parameter logic [BYTE_W-1:0] ERR_ABORT    = 8'h04
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hw_reset_evt,
    input  logic              comreset_evt,
    input  logic              cominit_evt,
    input  logic              srst_evt,
    input  logic              cmd_valid,
    input  logic [BYTE_W-1:0] cmd_code,
    input  logic [BYTE_W-1:0] feat_code,
    input  logic [BYTE_W-1:0] arg_cmd,
    input  logic [BYTE_W-1:0] arg_feat,
    input  logic [BYTE_W-1:0] arg_mask,
    input  logic [BYTE_W-1:0] arg_proto,
    output logic              res_valid,
    output logic [1:0]        res_kind,
    output logic [BYTE_W-1:0] res_proto,
    output logic [BYTE_W-1:0] res_status,
    output logic [BYTE_W-1:0] res_error
);
    lock_state_e       lock_state;
    logic [2:0]        kinds;
    lock_op_e          op_d, op_go;
    resp_kind_e        kind_d;
    logic [BYTE_W-1:0] proto_d, gen_proto, pick;
    logic              force_lock, cmd_go, gen_we, ent_we, take;
    logic              is_ctrl, is_vs, is_rsv;
    logic              tbl_hit, tbl_wr_ok, tbl_clear;
    logic [BYTE_W-1:0] tbl_proto;

    assign force_lock = hw_reset_evt || comreset_evt || cominit_evt;
    assign cmd_go     = cmd_valid && !force_lock;
    assign kinds      = lock_state;
    assign op_go      = cmd_go ? op_d : OP_NONE;
    assign tbl_clear  = force_lock || (op_go == OP_LOCK);

    vcl_classify #(.VS_LO(VS_LO), .VS_HI(VS_HI), .RSV_LO(RSV_LO),
                   .RSV_HI(RSV_HI), .CTRL_CODE(CTRL_CODE)) u_cls (
        .code(cmd_code), .is_ctrl(is_ctrl), .is_vs(is_vs), .is_rsv(is_rsv));

    vcl_lock_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .force_lock(force_lock),
        .op(op_go), .state(lock_state));

    vcl_proto_table #(.ENTRIES(ENTRIES)) u_tbl (
        .clk(clk), .rst_n(rst_n), .clear(tbl_clear),
        .look_cmd(cmd_code), .look_feat(feat_code),
        .hit(tbl_hit), .hit_proto(tbl_proto),
        .wr_req(cmd_go && ent_we), .wr_cmd(arg_cmd), .wr_feat(arg_feat),
        .wr_mask(arg_mask), .wr_proto(arg_proto), .wr_ok(tbl_wr_ok));

    // verdict for the presented command
    always_comb begin
        kind_d  = RK_STD;
        proto_d = '0;
        op_d    = OP_NONE;
        gen_we  = 1'b0;
        ent_we  = 1'b0;
        take    = 1'b0;
        pick    = '0;
        if (is_ctrl) begin
            kind_d = RK_CTRL;
            unique case (feat_code)
                FT_UNL_VS:  op_d = OP_ADD_VS;
                FT_UNL_RSV: op_d = OP_ADD_RSV;
                FT_UNL_IND: op_d = OP_ADD_IND;
                FT_LOCK:    op_d = OP_LOCK;
                FT_SET_GEN: if (lock_state != LK_LOCKED) gen_we = 1'b1;
                            else kind_d = RK_ABORT;
                FT_SET_ENT: if (lock_state != LK_LOCKED && tbl_wr_ok) ent_we = 1'b1;
                            else kind_d = RK_ABORT;
                default:    kind_d = RK_ABORT;
            endcase
        end else if (is_vs || is_rsv) begin
            if (kinds[2] && tbl_hit) begin
                take = 1'b1;
                pick = tbl_proto;
            end else if ((is_vs && kinds[0]) || (is_rsv && kinds[1])) begin
                take = 1'b1;
                pick = gen_proto;
            end
            if (take && pick != '0) begin
                kind_d  = RK_FWD;
                proto_d = pick;
            end else begin
                kind_d = RK_ABORT;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || tbl_clear) gen_proto <= '0;
        else if (cmd_go && gen_we) gen_proto <= arg_proto;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid  <= 1'b0;
            res_kind   <= RK_STD;
            res_proto  <= '0;
            res_status <= '0;
            res_error  <= '0;
        end else begin
            res_valid <= cmd_go;
            if (cmd_go) begin
                res_kind   <= kind_d;
                res_proto  <= proto_d;
                res_status <= (kind_d == RK_ABORT) ? ST_ABORT : ST_OK;
                res_error  <= (kind_d == RK_ABORT) ? ERR_ABORT : '0;
            end
        end
    end

    assert_drop_on_evt_R1: assert property (@(posedge clk) disable iff (!rst_n)
        force_lock |=> !res_valid);
    assert_srst_inert_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (srst_evt && !cmd_valid && !force_lock) |=> ($stable(lock_state) && $stable(gen_proto)));
    assert_locked_abort_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_go && lock_state == LK_LOCKED && (is_vs || is_rsv)) |=> res_kind == RK_ABORT);
    assert_std_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_go && !is_ctrl && !is_vs && !is_rsv) |=> (res_valid && res_kind == RK_STD));
    assert_fwd_nonzero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_kind == RK_FWD) |-> res_proto != '0);
    assert_locked_no_hit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        lock_state == LK_LOCKED |-> !tbl_hit);
    assert_one_reply_R12: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_go |=> res_valid);
endmodule

// File: tb/vcmd_lock_gate_test.sv
module vcmd_lock_gate_test;
    localparam int N = 3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic hw_reset_evt = 0, comreset_evt = 0, cominit_evt = 0, srst_evt = 0;
    logic cmd_valid = 0;
    logic [7:0] cmd_code = 0, feat_code = 0, arg_cmd = 0, arg_feat = 0, arg_mask = 0, arg_proto = 0;
    logic res_valid;
    logic [1:0] res_kind;
    logic [7:0] res_proto, res_status, res_error;

    int compared = 0, mismatched = 0;

    // reference model state
    logic [2:0] ms;
    logic [7:0] mgen;
    logic       tv [N];
    logic [7:0] tc [N], tf [N], tm [N], tp [N];

    always #10 clk = ~clk;

    vcmd_lock_gate #(.ENTRIES(N)) uut (
        .clk(clk), .rst_n(rst_n), .hw_reset_evt(hw_reset_evt),
        .comreset_evt(comreset_evt), .cominit_evt(cominit_evt), .srst_evt(srst_evt),
        .cmd_valid(cmd_valid), .cmd_code(cmd_code), .feat_code(feat_code),
        .arg_cmd(arg_cmd), .arg_feat(arg_feat), .arg_mask(arg_mask), .arg_proto(arg_proto),
        .res_valid(res_valid), .res_kind(res_kind), .res_proto(res_proto),
        .res_status(res_status), .res_error(res_error));

    task automatic model_clear();
        ms = 3'b000;
        mgen = 8'h00;
        for (int i = 0; i < N; i++) begin
            tv[i] = 0; tc[i] = 0; tf[i] = 0; tm[i] = 0; tp[i] = 0;
        end
    endtask

    task automatic model_step(input logic [7:0] c, f, ac, af, am, ap,
                              output logic [1:0] ek, output logic [7:0] ep);
        logic vs, rsv, took, done;
        logic [7:0] sel;
        int slot;
        ek = 2'd0; ep = 8'h00;
        vs  = (c >= 8'h80 && c <= 8'h8F);
        rsv = (c >= 8'hF2);
        if (c == 8'hF1) begin
            ek = 2'd3;
            case (f)
                8'hD5: ms = ms | 3'b001;
                8'h12: ms = ms | 3'b010;
                8'h32: ms = ms | 3'b100;
                8'hF0: model_clear();
                8'h87: if (ms != 0) mgen = ap; else ek = 2'd2;
                8'h88: begin
                    slot = -1;
                    for (int i = N - 1; i >= 0; i--)
                        if (tv[i] && tc[i] == ac && tf[i] == af && tm[i] == am) slot = i;
                    if (slot < 0)
                        for (int i = N - 1; i >= 0; i--) if (!tv[i]) slot = i;
                    if (ms == 0 || slot < 0) ek = 2'd2;
                    else begin
                        tv[slot] = 1; tc[slot] = ac; tf[slot] = af; tm[slot] = am; tp[slot] = ap;
                    end
                end
                default: ek = 2'd2;
            endcase
        end else if (vs || rsv) begin
            took = 0; done = 0; sel = 0;
            if (ms[2])
                for (int i = 0; i < N; i++)
                    if (!done && tv[i] && tc[i] == c && ((f ^ tf[i]) & tm[i]) == 0) begin
                        done = 1; took = 1; sel = tp[i];
                    end
            if (!done && ((vs && ms[0]) || (rsv && ms[1]))) begin
                took = 1; sel = mgen;
            end
            if (took && sel != 0) begin ek = 2'd1; ep = sel; end
            else ek = 2'd2;
        end
    endtask

    task automatic check_idle(input string req);
        compared++;
        if (res_valid !== 1'b0) begin
            mismatched++;
            $display("FAIL %s: res_valid actual %0b expected 0", req, res_valid);
        end
    endtask

    task automatic do_cmd(input logic [7:0] c, f, ac, af, am, ap, input string req);
        logic [1:0] ek;
        logic [7:0] ep, es, ee;
        @(negedge clk);
        cmd_valid = 1; cmd_code = c; feat_code = f;
        arg_cmd = ac; arg_feat = af; arg_mask = am; arg_proto = ap;
        model_step(c, f, ac, af, am, ap, ek, ep);
        es = (ek == 2'd2) ? 8'h51 : 8'h50;
        ee = (ek == 2'd2) ? 8'h04 : 8'h00;
        @(negedge clk);
        cmd_valid = 0;
        compared++;
        if (res_valid !== 1'b1 || res_kind !== ek || res_proto !== ep ||
            res_status !== es || res_error !== ee) begin
            mismatched++;
            $display("FAIL %s: cmd %h/%h actual v%0b k%0d p%h s%h e%h expected v1 k%0d p%h s%h e%h",
                     req, c, f, res_valid, res_kind, res_proto, res_status, res_error,
                     ek, ep, es, ee);
        end
    endtask

    task automatic pulse_evt(input int which, input logic with_cmd, input string req);
        @(negedge clk);
        hw_reset_evt = (which == 0); comreset_evt = (which == 1);
        cominit_evt  = (which == 2); srst_evt     = (which == 3);
        cmd_valid = with_cmd; cmd_code = 8'h25; feat_code = 8'h00;
        if (which != 3) model_clear();
        @(negedge clk);
        hw_reset_evt = 0; comreset_evt = 0; cominit_evt = 0; srst_evt = 0; cmd_valid = 0;
        if (which != 3) check_idle(req);
    endtask

    function automatic logic [7:0] pick_code();
        case ($urandom_range(0, 11))
            0: return 8'h85;  1: return 8'h8A;  2: return 8'hF3;  3: return 8'hFF;
            4: return 8'h80;  5: return 8'h25;  6: return 8'hEC;  7: return 8'h8F;
            default: return 8'hF1;
        endcase
    endfunction

    function automatic logic [7:0] pick_feat();
        case ($urandom_range(0, 7))
            0: return 8'hD5;  1: return 8'h12;  2: return 8'h32;  3: return 8'hF0;
            4: return 8'h87;  5: return 8'h88;  6: return 8'h99;
            default: return 8'($urandom_range(0, 31));
        endcase
    endfunction

    initial begin
        #(64'd200000 * 20);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        model_clear();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check_idle("R12");
        // locked behaviour
        do_cmd(8'h85, 8'h00, 0, 0, 0, 0, "R3");
        do_cmd(8'hF5, 8'h00, 0, 0, 0, 0, "R3");
        do_cmd(8'h25, 8'h00, 0, 0, 0, 0, "R4");
        do_cmd(8'hF1, 8'h87, 0, 0, 0, 8'h33, "R7");
        do_cmd(8'hF1, 8'h88, 8'h8A, 0, 0, 8'h44, "R11");
        // vendor unlock and general code
        do_cmd(8'hF1, 8'hD5, 0, 0, 0, 0, "R5");
        do_cmd(8'h85, 8'h00, 0, 0, 0, 0, "R8");
        do_cmd(8'hF1, 8'h87, 0, 0, 0, 8'h33, "R7");
        do_cmd(8'h85, 8'h00, 0, 0, 0, 0, "R8");
        do_cmd(8'hF5, 8'h00, 0, 0, 0, 0, "R8");
        do_cmd(8'hEC, 8'h00, 0, 0, 0, 0, "R4");
        pulse_evt(3, 0, "R2");
        do_cmd(8'h85, 8'h00, 0, 0, 0, 0, "R2");
        // listed kind and table
        do_cmd(8'hF1, 8'h32, 0, 0, 0, 0, "R5");
        do_cmd(8'hF1, 8'h88, 8'h8A, 8'h10, 8'hF0, 8'h44, "R11");
        do_cmd(8'h8A, 8'h1F, 0, 0, 0, 0, "R9");
        do_cmd(8'h8A, 8'h20, 0, 0, 0, 0, "R9");
        do_cmd(8'hF1, 8'h88, 8'h8A, 8'h00, 8'h00, 8'h55, "R11");
        do_cmd(8'h8A, 8'h1F, 0, 0, 0, 0, "R10");
        do_cmd(8'h8A, 8'h77, 0, 0, 0, 0, "R10");
        do_cmd(8'hF1, 8'h88, 8'h8A, 8'h10, 8'hF0, 8'h66, "R11");
        do_cmd(8'h8A, 8'h13, 0, 0, 0, 0, "R11");
        do_cmd(8'hF1, 8'h88, 8'hF3, 8'h01, 8'hFF, 8'h77, "R11");
        do_cmd(8'hF1, 8'h88, 8'h80, 8'h00, 8'h00, 8'h99, "R11");
        do_cmd(8'h80, 8'h00, 0, 0, 0, 0, "R11");
        do_cmd(8'hF3, 8'h01, 0, 0, 0, 0, "R9");
        do_cmd(8'hF3, 8'h02, 0, 0, 0, 0, "R9");
        do_cmd(8'hF1, 8'h88, 8'hF3, 8'h01, 8'hFF, 8'h00, "R11");
        do_cmd(8'hF3, 8'h01, 0, 0, 0, 0, "R9");
        do_cmd(8'hF1, 8'h99, 0, 0, 0, 0, "R13");
        do_cmd(8'h8A, 8'h13, 0, 0, 0, 0, "R13");
        do_cmd(8'hF1, 8'h12, 0, 0, 0, 0, "R5");
        do_cmd(8'hF5, 8'h00, 0, 0, 0, 0, "R8");
        // lock and reset events
        do_cmd(8'hF1, 8'hF0, 0, 0, 0, 0, "R6");
        do_cmd(8'h8A, 8'h13, 0, 0, 0, 0, "R6");
        do_cmd(8'hF1, 8'hD5, 0, 0, 0, 0, "R5");
        do_cmd(8'h85, 8'h00, 0, 0, 0, 0, "R6");
        for (int w = 0; w < 3; w++) begin
            do_cmd(8'hF1, 8'hD5, 0, 0, 0, 0, "R5");
            do_cmd(8'hF1, 8'h87, 0, 0, 0, 8'h21, "R7");
            pulse_evt(w, w == 1, "R1");
            do_cmd(8'h85, 8'h00, 0, 0, 0, 0, "R1");
        end
        // random mix
        for (int k = 0; k < 800; k++) begin
            if ($urandom_range(0, 39) == 0)
                pulse_evt($urandom_range(0, 3), 1'($urandom_range(0, 1)), "R1");
            else
                do_cmd(pick_code(), pick_feat(),
                       ($urandom_range(0, 1) == 0) ? 8'h8A : 8'hF3,
                       8'($urandom_range(0, 3)),
                       ($urandom_range(0, 1) == 0) ? 8'hFF : 8'h0F,
                       8'($urandom_range(0, 3)), "R9");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule